// File: doc/BRIEF.md
# Dual-Supply Power-Up Enable Sequencer

This block decides when the signal-repeating channels of an isolated two-wire bus repeater may act on the bus. It watches two independent supplies, each reported by two comparator flags: one that says the supply is above the internal startup threshold, and one that says it is above the minimum valid operating level. The flags come from analog comparators and are treated here as asynchronous digital inputs.

Enable needs two things. Both supplies must report the valid level. A fixed qualification delay must also have run out, and that delay starts only once both supplies have passed the startup threshold. Any lost condition drops the enable at once. This covers power-down as much as power-up. While the channels are disabled, every line the repeater could pull low is held released, so a supply that is coming up or failing never drags the bus low.

The delay length is derived from two parameters, the clock frequency in kHz and the required delay in ns. It is rounded up to whole cycles, so the real delay is never shorter than the one asked for. Each flag passes through a flop synchronizer before use.

Top module: `supply_seq_gate`

## Requirements
- R1: While `rst_n` is low, `chan_en` is 0 and every bit of `line_pull` is 0 (released), whatever the flags and requests are.
- R2: `chan_en` rises only after both startup flags have been high and synchronized for DELAY_CYCLES = ceil(DELAY_NS × CLK_KHZ / 10^6) consecutive clock edges. With SYNC_STAGES = 2 and both valid flags already high, it rises on the edge SYNC_STAGES + DELAY_CYCLES after both startup flags go high.
- R3: The delay count restarts from zero whenever either synchronized startup flag is low, including partway through the count.
- R4: `chan_en` is 0 whenever either synchronized valid flag is low, even after the delay has expired.
- R5: A valid flag may rise before or after the delay expires. If the delay has already expired, `chan_en` rises as soon as both synchronized valid flags are high, with no new delay.
- R6: `chan_en` falls in the same cycle that any synchronized startup or valid flag reads low. This is how power-down is gated.
- R7: `line_pull[i]` is `line_req[i]` when `chan_en` is 1 and 0 (released) otherwise. Bit i of the request maps to bit i of the output.
- R8: Each flag reaches the enable logic through exactly SYNC_STAGES flops (default 2), so a flag change on the inputs shows at `chan_en` after SYNC_STAGES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock of frequency CLK_KHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa_boot | input | 1 | Supply A above startup threshold (asynchronous) |
| sa_good | input | 1 | Supply A above minimum valid level (asynchronous) |
| sb_boot | input | 1 | Supply B above startup threshold (asynchronous) |
| sb_good | input | 1 | Supply B above minimum valid level (asynchronous) |
| line_req | input | N_LINES | Per-line request to pull the bus line low |
| chan_en | output | 1 | Channels enabled |
| line_pull | output | N_LINES | Gated pull-low drive, 0 = released |

## Verification
The assertions assume the flags are level signals that can change at any time but that the counter only sees after synchronization. They also assume the reset is asynchronous and arrives with any flag pattern. The stimulus changes flags and requests only on falling clock edges and holds each pattern for a counted number of edges. Each expected enable value is then worked out from the synchronizer depth plus the delay count. The bench drops a startup flag partway through a count to expose a timer that does not restart. It also raises the valid flags both before and after expiry. To keep runs short it shrinks the delay to ten cycles through the frequency and delay parameters.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
   // Flag positions inside the synchronized flag vector
   localparam int FLAG_A_BOOT = 0;
   localparam int FLAG_A_GOOD = 1;
   localparam int FLAG_B_BOOT = 2;
   localparam int FLAG_B_GOOD = 3;
   localparam int N_FLAGS     = 4;

   // Cycles needed to cover delay_ns at clk_khz, rounded up
   function automatic int delay_to_cycles(input int clk_khz, input int delay_ns);
      longint prod;
      prod = longint'(clk_khz) * longint'(delay_ns);
      return int'((prod + 64'd999999) / 64'd1000000);
   endfunction
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   initial begin
      assert (STAGES >= 2) else $error("flag_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $error("flag_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/qual_timer.sv
module qual_timer #(
   parameter int DELAY_CYCLES = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   initial begin
      assert (DELAY_CYCLES >= 0) else $error("qual_timer: negative delay");
   end

   if (DELAY_CYCLES == 0) begin : g_nodelay
      assign expired = run;
   end else begin : g_count
      localparam int CW = $clog2(DELAY_CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYCLES);

      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (!run)           cnt_q <= '0;
         else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end

      assign expired = run && (cnt_q == LIMIT);

      // R3: a low run input clears the count on the next edge
      assert_restart_on_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> cnt_q == '0);

      // R2: the count advances by exactly one per qualifying edge
      assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (run && cnt_q != LIMIT) |=> cnt_q == $past(cnt_q) + 1'b1);

      // R2: the count never runs past its limit
      assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LIMIT);
   end
endmodule

// File: rtl/line_gate.sv
module line_gate #(
   parameter int N_LINES = 2
) (
   input  logic               en,
   input  logic [N_LINES-1:0] req,
   output logic [N_LINES-1:0] pull
);
   initial begin
      assert (N_LINES >= 1) else $error("line_gate: N_LINES must be at least 1");
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      assign pull[i] = req[i] & en;
   end
endmodule

// File: rtl/supply_seq_gate.sv
module supply_seq_gate
   import supply_seq_pkg::*;
#(
   parameter int CLK_KHZ     = 100000,
   parameter int DELAY_NS    = 40000,
   parameter int SYNC_STAGES = 2,
   parameter int N_LINES     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sa_boot,
   input  logic               sa_good,
   input  logic               sb_boot,
   input  logic               sb_good,
   input  logic [N_LINES-1:0] line_req,
   output logic               chan_en,
   output logic [N_LINES-1:0] line_pull
);
   localparam int DELAY_CYCLES = delay_to_cycles(CLK_KHZ, DELAY_NS);

   initial begin
      assert (CLK_KHZ > 0) else $error("supply_seq_gate: CLK_KHZ must be positive");
      assert (DELAY_NS >= 0) else $error("supply_seq_gate: DELAY_NS must not be negative");
   end

   logic [N_FLAGS-1:0] raw_flags;
   logic [N_FLAGS-1:0] syn_flags;
   logic               both_boot;
   logic               both_good;
   logic               delay_done;

   always_comb begin
      raw_flags              = '0;
      raw_flags[FLAG_A_BOOT] = sa_boot;
      raw_flags[FLAG_A_GOOD] = sa_good;
      raw_flags[FLAG_B_BOOT] = sb_boot;
      raw_flags[FLAG_B_GOOD] = sb_good;
   end

   flag_sync #(.WIDTH(N_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_flags),
      .q_sync  (syn_flags)
   );

   assign both_boot = syn_flags[FLAG_A_BOOT] & syn_flags[FLAG_B_BOOT];
   assign both_good = syn_flags[FLAG_A_GOOD] & syn_flags[FLAG_B_GOOD];

   qual_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (both_boot),
      .expired (delay_done)
   );

   assign chan_en = delay_done & both_good;

   line_gate #(.N_LINES(N_LINES)) u_gate (
      .en   (chan_en),
      .req  (line_req),
      .pull (line_pull)
   );

   // R2: enable is only seen once the timer reports expiry
   assert_en_needs_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en |-> delay_done);

   // R4: enable never coexists with a missing valid flag
   assert_en_needs_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en |-> (syn_flags[FLAG_A_GOOD] && syn_flags[FLAG_B_GOOD]));

   // R7: the gated lines stay released while disabled
   assert_released_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |-> line_pull == '0);

   // R6: a startup flag seen low drops the enable in the same cycle
   assert_drop_on_boot_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !both_boot |-> !chan_en);
endmodule

// File: tb/sim_supply_seq_gate.sv
module sim_supply_seq_gate;
   localparam int NL = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sa_boot = 1'b0, sa_good = 1'b0, sb_boot = 1'b0, sb_good = 1'b0;
   logic [NL-1:0] line_req = '0;
   logic          chan_en;
   logic [NL-1:0] line_pull;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   // 100 MHz clock and a 100 ns delay give a 10-cycle qualification window
   supply_seq_gate #(.CLK_KHZ(100000), .DELAY_NS(100), .SYNC_STAGES(2), .N_LINES(NL)) u0 (
      .clk(clk), .rst_n(rst_n),
      .sa_boot(sa_boot), .sa_good(sa_good), .sb_boot(sb_boot), .sb_good(sb_good),
      .line_req(line_req), .chan_en(chan_en), .line_pull(line_pull)
   );

   // Row: {flags a_boot,a_good,b_boot,b_good}, edges to wait, expected enable
   localparam int NV = 17;
   localparam logic [12:0] VEC [NV] = '{
      {4'b1111, 8'd11, 1'b0},  // R2 one edge short of expiry
      {4'b1111, 8'd1,  1'b1},  // R2 expiry on edge 2+10
      {4'b1011, 8'd1,  1'b1},  // R8 drop not yet through sync
      {4'b1011, 8'd1,  1'b0},  // R4 R6 valid lost
      {4'b1111, 8'd2,  1'b1},  // R5 valid back after expiry, no new delay
      {4'b1101, 8'd2,  1'b0},  // R6 startup flag lost
      {4'b1111, 8'd11, 1'b0},  // R3 count started over
      {4'b1111, 8'd1,  1'b1},  // R2
      {4'b0111, 8'd2,  1'b0},  // R6
      {4'b1111, 8'd6,  1'b0},  // R3 partial count
      {4'b0111, 8'd2,  1'b0},  // R3 drop during count
      {4'b1111, 8'd11, 1'b0},  // R3 restarted from zero
      {4'b1111, 8'd1,  1'b1},  // R3
      {4'b0000, 8'd3,  1'b0},  // R6 power-down
      {4'b1010, 8'd20, 1'b0},  // R4 delay expired, valid still low
      {4'b1111, 8'd1,  1'b0},  // R8 valid in first sync stage only
      {4'b1111, 8'd1,  1'b1}   // R5 valid rising after expiry
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive(input logic [3:0] f);
      {sa_boot, sa_good, sb_boot, sb_good} = f;
   endtask

   initial begin
      // R1: reset holds everything released
      drive(4'b1111);
      line_req = '1;
      repeat (3) @(negedge clk);
      chk("R1 chan_en in reset", 32'(chan_en), 32'd0);
      chk("R1 line_pull in reset", 32'(line_pull), 32'd0);
      drive(4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 chan_en after reset", 32'(chan_en), 32'd0);

      for (int k = 0; k < NV; k++) begin
         drive(VEC[k][12:9]);
         repeat (int'(VEC[k][8:1])) @(posedge clk);
         @(negedge clk);
         chk($sformatf("R2-set row %0d chan_en", k), 32'(chan_en), 32'(VEC[k][0]));
         chk($sformatf("R7 row %0d line_pull", k), 32'(line_pull),
             VEC[k][0] ? 32'(2'b11) : 32'd0);
      end

      // R7: per-line mapping while enabled
      line_req = 2'b01;
      #1;
      chk("R7 line 0 only", 32'(line_pull), 32'(2'b01));
      line_req = 2'b10;
      #1;
      chk("R7 line 1 only", 32'(line_pull), 32'(2'b10));

      // R1: reset in mid-run forces release at once
      @(negedge clk);
      line_req = '1;
      rst_n = 1'b0;
      #1;
      chk("R1 async reset chan_en", 32'(chan_en), 32'd0);
      chk("R1 async reset line_pull", 32'(line_pull), 32'd0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule